// File: doc/BRIEF.md
# Shared Non-Blocking Instruction Cache

This block is a second-level instruction cache that serves one cluster of cores. Each core has a tiny private instruction cache of its own. Only when that private cache misses does the core send a line request here, and the core then stalls until the line comes back. The cache has one tag/data port. A round-robin arbiter picks at most one requester per cycle for that port, and whole lines are returned on a shared data bus. A per-requester valid mask on that bus names the receivers.

The cache keeps serving hits while earlier misses are still waiting on the backing instruction memory. Each outstanding miss occupies one miss status holding register (MSHR), and the number of MSHRs is a parameter. A later miss to a line that is already outstanding does not go to memory again; the requester is added to that entry's waiter set instead. Misses go to the backing memory through a valid/ready request channel and come back on a response channel tagged with the MSHR index.

Back-pressure rules:
- A request transfers on a cycle where `req_valid[i]` and `req_ready[i]` are both high.
- A request that is not accepted must stay valid with the same address.
- `mem_req_valid` and the request fields stay stable until `mem_req_ready`.
- Responses in both directions cannot be stalled, because the cores are already waiting for them and a fill always takes the port.

Top module: `shared_icache`

## Requirements
- R1: After reset every line is invalid, no MSHR is in use, `rsp_valid` and `mem_req_valid` are low, and the first request to any line is a miss that produces exactly one memory request.
- R2: At most one bit of `req_ready` is high in any cycle, only for a requester whose `req_valid` is high. No request is accepted in a cycle where `mem_rsp_valid` is high, because the fill uses the port.
- R3: A hit is answered in the cycle after acceptance: `rsp_valid[i]` is high and `rsp_data` holds the line. This holds even while other misses are outstanding, and a hit issues no memory request.
- R4: An accepted miss to a line with no MSHR allocates one. The memory request carries the line address (the byte address shifted right by log2 of the line size) and the MSHR index as the tag. It stays valid with stable fields until `mem_req_ready`.
- R5: A miss to a line that already has an MSHR issues no new memory request. All merged requesters receive the line in the same cycle, and no two busy MSHRs ever hold the same line.
- R6: While all MSHRs are busy, a miss to a line without an MSHR is not accepted (`req_ready` stays low) and no memory request is issued for it. Hits from other requesters are still accepted.
- R7: A memory response writes the line and tag in one cycle. In the next cycle `rsp_valid` equals the set of waiters recorded in that MSHR, `rsp_data` equals the returned line, and the entry is freed. Later requests to that line hit.
- R8: Arbitration is round-robin. With every requester continuously valid, consecutive grants step through the indices in increasing order with wrap-around.
- R9: The cache is direct-mapped. The offset is the low log2(LINE_BYTES) bits of the address and the index is the next log2(CACHE_BYTES/LINE_BYTES) bits. A line at the same index with a different tag replaces the resident line. LINE_BYTES may be 8 or 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | NUM_REQ | Per-requester line request valid |
| req_ready | output | NUM_REQ | Per-requester accept, at most one bit high |
| req_addr | input | NUM_REQ*ADDR_W | Packed byte addresses, requester i in slice i |
| rsp_valid | output | NUM_REQ | Mask of requesters receiving `rsp_data` this cycle |
| rsp_data | output | LINE_BYTES*8 | Returned line |
| mem_req_valid | output | 1 | Memory line request valid |
| mem_req_ready | input | 1 | Memory accepts request |
| mem_req_line | output | ADDR_W-log2(LINE_BYTES) | Line address requested |
| mem_req_tag | output | log2(NUM_MSHR), min 1 | MSHR index of the request |
| mem_rsp_valid | input | 1 | Fill data valid |
| mem_rsp_tag | input | log2(NUM_MSHR), min 1 | MSHR index being filled |
| mem_rsp_data | input | LINE_BYTES*8 | Fill line |

## Verification
Some properties are checked by assertions on every cycle:
- the single-lookup rule and the ready/valid relation;
- hit answers one cycle after acceptance;
- refusal while the MSHRs are full;
- no duplicate busy lines;
- stable memory requests under back-pressure;
- fills only to entries that are waiting;
- the fill-then-hit link in the line store;
- the round-robin step under full load.

Other behaviour only the bench scenarios can show:
- that merging really saves memory traffic;
- that merged waiters are released together;
- that a hit completes while a miss is held back by a stalled memory;
- that a conflicting tag evicts a resident line;
- that every returned line carries the right contents under random interleavings.

// File: rtl/icache_pkg.sv
package icache_pkg;
  typedef enum logic [1:0] {
    MS_FREE  = 2'd0,
    MS_ISSUE = 2'd1,
    MS_WAIT  = 2'd2
  } mshr_state_e;
endpackage

// File: rtl/icache_rr_arb.sv
module icache_rr_arb #(
  parameter int N  = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [N-1:0]  req,
  output logic          gnt_valid,
  output logic [IW-1:0] gnt_idx
);
  logic [IW-1:0] ptr_q;
  logic          armed_q;

  always_comb begin
    int c;
    gnt_valid = 1'b0;
    gnt_idx   = '0;
    for (int k = 0; k < N; k++) begin
      c = (int'(ptr_q) + k) % N;
      if (en && !gnt_valid && req[c]) begin
        gnt_valid = 1'b1;
        gnt_idx   = IW'(c);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q   <= '0;
      armed_q <= 1'b0;
    end else begin
      armed_q <= 1'b1;
      if (gnt_valid) ptr_q <= (gnt_idx == IW'(N - 1)) ? '0 : gnt_idx + 1'b1;
    end
  end

  AST_RR_ROTATE: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && $past(gnt_valid) && en && (&req)) |->
      (gnt_idx == (($past(gnt_idx) == IW'(N - 1)) ? '0 : $past(gnt_idx) + 1'b1))); // R8
endmodule

// File: rtl/icache_line_store.sv
module icache_line_store #(
  parameter int NUM_LINES = 256,
  parameter int IDX_W     = 8,
  parameter int TAG_W     = 20,
  parameter int LINE_W    = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  idx,
  input  logic [TAG_W-1:0]  lk_tag,
  input  logic              wr_en,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [LINE_W-1:0] wr_data,
  output logic              hit,
  output logic [LINE_W-1:0] rd_data
);
  logic [NUM_LINES-1:0] vld_q;
  logic [TAG_W-1:0]     tag_q  [NUM_LINES];
  logic [LINE_W-1:0]    line_q [NUM_LINES];

  assign hit = vld_q[idx] && (tag_q[idx] == lk_tag);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     vld_q      <= '0;
    else if (wr_en) vld_q[idx] <= 1'b1;
  end

  // single port: a write also drives the read register with the written line
  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q[idx]  <= wr_tag;
      line_q[idx] <= wr_data;
      rd_data     <= wr_data;
    end else begin
      rd_data <= line_q[idx];
    end
  end

  AST_FILL_THEN_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (!(idx == $past(idx) && lk_tag == $past(wr_tag)) || hit)); // R7
endmodule

// File: rtl/icache_mshr_file.sv
module icache_mshr_file
  import icache_pkg::*;
#(
  parameter int NUM_MSHR = 2,
  parameter int NUM_REQ  = 4,
  parameter int LADDR_W  = 28,
  parameter int MTAG_W   = 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [LADDR_W-1:0] lk_line,
  input  logic               alloc_en,
  input  logic               merge_en,
  input  logic [NUM_REQ-1:0] req_onehot,
  output logic               match,
  output logic               free_avail,
  output logic               mem_req_valid,
  input  logic               mem_req_ready,
  output logic [LADDR_W-1:0] mem_req_line,
  output logic [MTAG_W-1:0]  mem_req_tag,
  input  logic               fill_en,
  input  logic [MTAG_W-1:0]  fill_tag,
  output logic [LADDR_W-1:0] fill_line,
  output logic [NUM_REQ-1:0] fill_waiters
);
  mshr_state_e        st_q [NUM_MSHR];
  logic [LADDR_W-1:0] ln_q [NUM_MSHR];
  logic [NUM_REQ-1:0] wt_q [NUM_MSHR];
  logic [NUM_MSHR-1:0] hit_vec;
  logic [MTAG_W-1:0]  free_idx, iss_idx, lock_idx_q;
  logic               iss_valid, lock_q, iss_fire;

  always_comb begin
    free_avail = 1'b0;
    free_idx   = '0;
    iss_valid  = lock_q;
    iss_idx    = lock_idx_q;
    for (int e = 0; e < NUM_MSHR; e++) begin
      hit_vec[e] = (st_q[e] != MS_FREE) && (ln_q[e] == lk_line);
      if (!free_avail && st_q[e] == MS_FREE) begin
        free_avail = 1'b1;
        free_idx   = MTAG_W'(e);
      end
      if (!iss_valid && st_q[e] == MS_ISSUE) begin
        iss_valid = 1'b1;
        iss_idx   = MTAG_W'(e);
      end
    end
  end

  assign match         = |hit_vec;
  assign iss_fire      = iss_valid && mem_req_ready;
  assign mem_req_valid = iss_valid;
  assign mem_req_line  = ln_q[iss_idx];
  assign mem_req_tag   = iss_idx;
  assign fill_line     = ln_q[fill_tag];
  assign fill_waiters  = wt_q[fill_tag];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q     <= 1'b0;
      lock_idx_q <= '0;
      for (int e = 0; e < NUM_MSHR; e++) begin
        st_q[e] <= MS_FREE;
        ln_q[e] <= '0;
        wt_q[e] <= '0;
      end
    end else begin
      lock_q     <= iss_valid && !mem_req_ready;
      lock_idx_q <= iss_idx;
      for (int e = 0; e < NUM_MSHR; e++) begin
        if (fill_en && fill_tag == MTAG_W'(e)) begin
          st_q[e] <= MS_FREE;
          wt_q[e] <= '0;
        end else begin
          if (alloc_en && free_idx == MTAG_W'(e)) begin
            st_q[e] <= MS_ISSUE;
            ln_q[e] <= lk_line;
            wt_q[e] <= req_onehot;
          end else if (merge_en && hit_vec[e]) begin
            wt_q[e] <= wt_q[e] | req_onehot;
          end
          if (st_q[e] == MS_ISSUE && iss_fire && iss_idx == MTAG_W'(e)) st_q[e] <= MS_WAIT;
        end
      end
    end
  end

  AST_NO_DUP_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(hit_vec) <= 1); // R5
  AST_MEMREQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_req_line) && $stable(mem_req_tag))); // R4
  AST_FILL_WAITING: assert property (@(posedge clk) disable iff (!rst_n)
    fill_en |-> (st_q[fill_tag] == MS_WAIT)); // R7
endmodule

// File: rtl/shared_icache.sv
module shared_icache #(
  parameter int NUM_REQ     = 4,
  parameter int NUM_MSHR    = 2,
  parameter int ADDR_W      = 32,
  parameter int CACHE_BYTES = 4096,
  parameter int LINE_BYTES  = 16
) (
  input  logic                                             clk,
  input  logic                                             rst_n,
  input  logic [NUM_REQ-1:0]                               req_valid,
  output logic [NUM_REQ-1:0]                               req_ready,
  input  logic [NUM_REQ*ADDR_W-1:0]                        req_addr,
  output logic [NUM_REQ-1:0]                               rsp_valid,
  output logic [LINE_BYTES*8-1:0]                          rsp_data,
  output logic                                             mem_req_valid,
  input  logic                                             mem_req_ready,
  output logic [ADDR_W-$clog2(LINE_BYTES)-1:0]             mem_req_line,
  output logic [$clog2(NUM_MSHR > 1 ? NUM_MSHR : 2)-1:0]   mem_req_tag,
  input  logic                                             mem_rsp_valid,
  input  logic [$clog2(NUM_MSHR > 1 ? NUM_MSHR : 2)-1:0]   mem_rsp_tag,
  input  logic [LINE_BYTES*8-1:0]                          mem_rsp_data
);
  localparam int LINE_W    = LINE_BYTES * 8;
  localparam int OFF_W     = $clog2(LINE_BYTES);
  localparam int NUM_LINES = CACHE_BYTES / LINE_BYTES;
  localparam int IDX_W     = $clog2(NUM_LINES);
  localparam int LADDR_W   = ADDR_W - OFF_W;
  localparam int TAG_W     = LADDR_W - IDX_W;
  localparam int MTAG_W    = $clog2(NUM_MSHR > 1 ? NUM_MSHR : 2);
  localparam int RID_W     = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1;

  logic               gnt_valid, hit, match, free_avail;
  logic [RID_W-1:0]   gnt_idx;
  logic [ADDR_W-1:0]  g_addr;
  logic [LADDR_W-1:0] g_line, fill_line;
  logic [NUM_REQ-1:0] gnt_onehot, fill_waiters, rsp_valid_q;
  logic               lk_hit, lk_merge, lk_alloc;
  logic [IDX_W-1:0]   port_idx;

  icache_rr_arb #(.N(NUM_REQ)) u_arb (
    .clk(clk), .rst_n(rst_n), .en(!mem_rsp_valid), .req(req_valid),
    .gnt_valid(gnt_valid), .gnt_idx(gnt_idx)
  );

  assign g_addr     = req_addr[int'(gnt_idx)*ADDR_W +: ADDR_W];
  assign g_line     = g_addr[ADDR_W-1:OFF_W];
  assign gnt_onehot = gnt_valid ? (NUM_REQ'(1) << gnt_idx) : '0;
  assign port_idx   = mem_rsp_valid ? fill_line[IDX_W-1:0] : g_line[IDX_W-1:0];

  icache_line_store #(.NUM_LINES(NUM_LINES), .IDX_W(IDX_W), .TAG_W(TAG_W), .LINE_W(LINE_W)) u_store (
    .clk(clk), .rst_n(rst_n), .idx(port_idx), .lk_tag(g_line[LADDR_W-1:IDX_W]),
    .wr_en(mem_rsp_valid), .wr_tag(fill_line[LADDR_W-1:IDX_W]), .wr_data(mem_rsp_data),
    .hit(hit), .rd_data(rsp_data)
  );

  assign lk_hit   = gnt_valid && hit;
  assign lk_merge = gnt_valid && !hit && match;
  assign lk_alloc = gnt_valid && !hit && !match && free_avail;

  icache_mshr_file #(.NUM_MSHR(NUM_MSHR), .NUM_REQ(NUM_REQ), .LADDR_W(LADDR_W), .MTAG_W(MTAG_W)) u_mshr (
    .clk(clk), .rst_n(rst_n), .lk_line(g_line), .alloc_en(lk_alloc), .merge_en(lk_merge),
    .req_onehot(gnt_onehot), .match(match), .free_avail(free_avail),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_line(mem_req_line), .mem_req_tag(mem_req_tag),
    .fill_en(mem_rsp_valid), .fill_tag(mem_rsp_tag),
    .fill_line(fill_line), .fill_waiters(fill_waiters)
  );

  assign req_ready = (lk_hit || lk_merge || lk_alloc) ? gnt_onehot : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             rsp_valid_q <= '0;
    else if (mem_rsp_valid) rsp_valid_q <= fill_waiters;
    else if (lk_hit)        rsp_valid_q <= gnt_onehot;
    else                    rsp_valid_q <= '0;
  end
  assign rsp_valid = rsp_valid_q;

  AST_ONE_LOOKUP: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(req_ready) && ((req_ready & ~req_valid) == '0)); // R2
  AST_FILL_OWNS_PORT: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rsp_valid |-> (req_ready == '0)); // R2
  AST_HIT_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    ((req_ready != '0) && hit) |=> ((rsp_valid & $past(req_ready)) != '0)); // R3
  AST_FULL_REFUSES: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_valid && !hit && !match && !free_avail) |-> (req_ready == '0)); // R6
endmodule

// File: tb/shared_icache_tb.sv
module shared_icache_tb;
  localparam int NR  = 4;
  localparam int NM  = 2;
  localparam int AW  = 32;
  localparam int LW  = 128;
  localparam int LAW = 28;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NR-1:0]   req_valid = '0;
  logic [NR-1:0]   req_ready;
  logic [NR*AW-1:0] req_addr = '0;
  logic [NR-1:0]   rsp_valid;
  logic [LW-1:0]   rsp_data;
  logic            mem_req_valid;
  logic            mem_req_ready = 1'b0;
  logic [LAW-1:0]  mem_req_line;
  logic [0:0]      mem_req_tag;
  logic            mem_rsp_valid = 1'b0;
  logic [0:0]      mem_rsp_tag = '0;
  logic [LW-1:0]   mem_rsp_data = '0;

  int checks = 0, errors = 0, cyc = 0, memreqs = 0;
  bit mem_hold = 1'b0, mem_rand = 1'b0;
  logic [LAW-1:0] last_line = '0;

  shared_icache u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready), .mem_req_line(mem_req_line), .mem_req_tag(mem_req_tag),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_tag(mem_rsp_tag), .mem_rsp_data(mem_rsp_data)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [LW-1:0] exp_line(input logic [LAW-1:0] l);
    logic [LW-1:0] r;
    for (int k = 0; k < LW / 32; k++) r[k*32 +: 32] = (32'(l) * 32'h9E3779B1) + (32'(k) * 32'h01010101);
    return r;
  endfunction

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [LW-1:0] act, input logic [LW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  // backing memory: in-order queue, latency fixed or random
  logic [LAW-1:0] q_line [16];
  logic [0:0]     q_tag  [16];
  int             q_due  [16];
  int qh = 0, qt = 0, qn = 0;
  initial begin
    forever begin
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      if (qn > 0 && !mem_hold && cyc >= q_due[qh]) begin
        mem_rsp_valid = 1'b1;
        mem_rsp_tag   = q_tag[qh];
        mem_rsp_data  = exp_line(q_line[qh]);
        qh = (qh + 1) % 16;
        qn--;
      end
      mem_req_ready = mem_rand ? ($urandom % 3 != 0) : 1'b1;
      #1;
      if (rst_n && mem_req_valid && mem_req_ready) begin
        q_line[qt] = mem_req_line;
        q_tag[qt]  = mem_req_tag;
        q_due[qt]  = cyc + 2 + (mem_rand ? int'($urandom % 8) : 0);
        qt = (qt + 1) % 16;
        qn++;
        memreqs++;
        last_line = mem_req_line;
      end
    end
  end

  task automatic core_txn(input int i, input logic [AW-1:0] a, output int acc_c, output int rsp_c);
    @(negedge clk);
    req_valid[i] = 1'b1;
    req_addr[i*AW +: AW] = a;
    forever begin
      #1;
      if (req_ready[i]) break;
      @(negedge clk);
    end
    acc_c = cyc;
    @(negedge clk);
    req_valid[i] = 1'b0;
    forever begin
      #1;
      if (rsp_valid[i]) break;
      @(negedge clk);
    end
    rsp_c = cyc;
    chk(rsp_data == exp_line(a[AW-1:4]), "R7", "returned line", rsp_data, exp_line(a[AW-1:4]));
  endtask

  task automatic run_core(input int i);
    int ac, rc;
    logic [AW-1:0] pool [8];
    pool = '{32'h40, 32'h80, 32'h100, 32'h1040, 32'h200, 32'h2040, 32'h300, 32'h90};
    for (int n = 0; n < 50; n++) begin
      core_txn(i, pool[$urandom % 8] | AW'($urandom % 16), ac, rc);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  localparam logic [AW-1:0] A = 32'h40, B = 32'h80, C = 32'h100, D = 32'h200,
                            E = 32'h300, F = 32'h400, G = 32'h1040;

  initial begin
    int a0, r0, a1, r1, a2, r2, a3, r3, base, prev, idx;
    bit d0, d1, d2, blocked;
    void'($urandom(32'd20240611));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk(rsp_valid == '0, "R1", "rsp_valid after reset", LW'(rsp_valid), '0);
    chk(mem_req_valid == 1'b0, "R1", "mem_req_valid after reset", LW'(mem_req_valid), '0);
    chk(req_ready == '0, "R1", "req_ready idle", LW'(req_ready), '0);

    // cold miss
    base = memreqs;
    core_txn(0, A, a0, r0);
    chk(memreqs - base == 1, "R1", "cold miss memory requests", LW'(memreqs - base), 1);
    chk(last_line == A[AW-1:4], "R4", "memory line address", LW'(last_line), LW'(A[AW-1:4]));

    // plain hit
    base = memreqs;
    core_txn(1, A + 8, a1, r1);
    chk(r1 - a1 == 1, "R3", "hit latency", LW'(r1 - a1), 1);
    chk(memreqs == base, "R3", "hit memory requests", LW'(memreqs - base), 0);

    // hit under miss
    mem_hold = 1'b1; d0 = 0;
    fork begin core_txn(0, B, a0, r0); d0 = 1; end join_none
    repeat (5) @(negedge clk);
    core_txn(1, A + 4, a1, r1);
    chk(r1 - a1 == 1, "R3", "hit latency under miss", LW'(r1 - a1), 1);
    chk(d0 == 0, "R3", "miss still outstanding", LW'(d0), 0);
    mem_hold = 1'b0;
    wait (d0);

    // merge
    mem_hold = 1'b1; d0 = 0; d2 = 0; base = memreqs;
    fork
      begin core_txn(0, C, a0, r0); d0 = 1; end
      begin core_txn(2, C + 12, a2, r2); d2 = 1; end
    join_none
    repeat (6) @(negedge clk);
    chk(memreqs - base == 1, "R5", "merged memory requests", LW'(memreqs - base), 1);
    mem_hold = 1'b0;
    wait (d0 && d2);
    chk(r0 == r2, "R5", "merged waiters same cycle", LW'(r0), LW'(r2));

    // all MSHRs busy
    mem_hold = 1'b1; d0 = 0; d1 = 0; d2 = 0; base = memreqs;
    fork
      begin core_txn(0, D, a0, r0); d0 = 1; end
      begin core_txn(1, E, a1, r1); d1 = 1; end
    join_none
    repeat (6) @(negedge clk);
    fork begin core_txn(2, F, a2, r2); d2 = 1; end join_none
    blocked = 1'b1;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk); #2;
      if (req_ready[2]) blocked = 1'b0;
    end
    chk(blocked, "R6", "miss refused while full", LW'(blocked), 1);
    core_txn(3, A, a3, r3);
    chk(d2 == 0, "R6", "hit served while full", LW'(d2), 0);
    chk(memreqs - base == 2, "R6", "no request for refused miss", LW'(memreqs - base), 2);
    mem_hold = 1'b0;
    wait (d0 && d1 && d2);

    // direct-mapped eviction
    base = memreqs;
    core_txn(0, G, a0, r0);
    chk(memreqs - base == 1, "R9", "conflicting tag misses", LW'(memreqs - base), 1);
    core_txn(1, A, a1, r1);
    chk(memreqs - base == 2, "R9", "evicted line misses", LW'(memreqs - base), 2);
    core_txn(2, A + 4, a2, r2);
    chk(memreqs - base == 2 && r2 - a2 == 1, "R9", "resident line hits", LW'(memreqs - base), 2);

    // round-robin under full load
    @(negedge clk);
    for (int i = 0; i < NR; i++) req_addr[i*AW +: AW] = A;
    req_valid = '1;
    prev = -1;
    for (int k = 0; k < 8; k++) begin
      #1;
      chk($countones(req_ready) == 1, "R2", "single accept per cycle", LW'(req_ready), 0);
      idx = 0;
      for (int i = 0; i < NR; i++) if (req_ready[i]) idx = i;
      if (prev >= 0) chk(idx == (prev + 1) % NR, "R8", "round-robin order", LW'(idx), LW'((prev + 1) % NR));
      prev = idx;
      @(negedge clk);
    end
    req_valid = '0;
    repeat (3) @(negedge clk);

    // random traffic
    mem_rand = 1'b1;
    fork
      run_core(0);
      run_core(1);
      run_core(2);
      run_core(3);
    join
    repeat (5) @(negedge clk);
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule